// File: doc/BRIEF.md
# NAND flash command/address sequencer

This block turns single byte-write requests from a local-bus controller into NAND flash bus cycles. A request names a command, address or data byte. The block then raises the matching latch enable, drives the byte onto the 8-bit I/O bus, and pulses the active-low write strobe. When the cycle is over it gives a one-clock completion pulse. Only one request is handled at a time, and a request that arrives while the block is busy is dropped.

The block runs on a clock four times faster than the flash bus clock, so every length below is in quarter bus clocks. Each cycle has three parts: a setup part before the strobe falls, the strobe-low part, and a hold part after the strobe rises. Their lengths come from three configuration inputs (relaxed timing, hold extend, setup extend) and from a 4-bit wait count W. In normal mode a cycle lasts 2+W bus clocks. In relaxed mode it lasts 3+2·W bus clocks. An address cycle marked as the last one of its sequence is followed by an enforced quiet gap before the next cycle may start.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is asserted and after it, before any request, nand_we_n is 1 and nand_cle, nand_ale, nand_io_oe, nand_io_out, busy and done are 0.
- R2: During a cycle nand_io_oe is 1 and nand_io_out holds the request byte for the whole cycle. req_kind encoding: 0 = command (nand_cle=1, nand_ale=0), 1 = address (nand_ale=1, nand_cle=0), 2 and 3 = data (both latch enables 0). Outside a cycle the bus drives 0 with nand_io_oe=0.
- R3: Setup (enable and data valid, strobe still high) lasts, in fast clocks: normal mode 1, or 2 with setup extend; relaxed mode 0, or 4 with setup extend.
- R4: Hold (strobe high again, enables and data still valid) lasts, in fast clocks: normal mode 2, or 4 with hold extend; relaxed mode 4, or 6 with hold extend.
- R5: With relaxed timing off, a cycle lasts 4·(2+W) fast clocks, so two bus clocks when every option is zero.
- R6: With relaxed timing on, a cycle lasts 4·(3+2·W) fast clocks.
- R7: nand_we_n is low exactly once per cycle, for the cycle length minus setup minus hold.
- R8: After an address cycle with req_last_addr=1, busy stays 1 for a further 16·(2+W) fast clocks (normal) or 32·(2+W) (relaxed). During that gap the strobe is high and the enables and bus drive are off. The flag has no effect on command or data cycles, or when it is 0.
- R9: In the fast clock after a cycle (or its gap) ends, done is 1 for one clock and busy is 0. A request held in that clock starts the next cycle immediately.
- R10: A request is accepted only while busy is 0. Requests made while busy, and changes of byte, kind or any configuration input after acceptance, have no effect on the cycle in progress.
- R11: A latch enable never falls while the strobe is low or in the clock after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the flash bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_byte | input | 8 | Byte to drive |
| req_last_addr | input | 1 | Address cycle ends the address sequence |
| cfg_relaxed | input | 1 | Relaxed timing mode |
| cfg_hold_ext | input | 1 | Extended hold after the strobe |
| cfg_setup_ext | input | 1 | Extended setup before the strobe |
| cfg_wait | input | 4 | Wait count W |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io_out | output | 8 | Bus data |
| nand_io_oe | output | 1 | Bus output enable |
| busy | output | 1 | Cycle or gap in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach is a request that lands exactly in the done clock while a cycle is ending. It must be accepted and start a new cycle at once, yet requests one clock earlier are ignored. The bench reaches it by holding req_valid high across several back-to-back cycles, so every done clock carries a pending request. It also fires requests with changed configuration in the middle of cycles and gaps. A per-clock queue model then shows both that the boundary request is accepted and that the earlier ones are not.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_DATA  = 2'd2,
    KIND_DATA2 = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;

endpackage

// File: rtl/nand_seq_rst_sync.sv
module nand_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nand_seq_timing.sv
module nand_seq_timing #(
  parameter int SCY_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             relaxed,
  input  logic             hold_ext,
  input  logic             setup_ext,
  input  logic [SCY_W-1:0] wait_cnt,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] strobe_len,
  output logic [CNT_W-1:0] hold_len,
  output logic [CNT_W-1:0] gap_len
);

  // Quarter-clock constants, fractional values rounded to quarters.
  localparam logic [CNT_W-1:0] N_SETUP_S = CNT_W'(1);
  localparam logic [CNT_W-1:0] N_SETUP_L = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_HOLD_S  = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_HOLD_L  = CNT_W'(4);
  localparam logic [CNT_W-1:0] R_SETUP_S = CNT_W'(0);
  localparam logic [CNT_W-1:0] R_SETUP_L = CNT_W'(4);
  localparam logic [CNT_W-1:0] R_HOLD_S  = CNT_W'(4);
  localparam logic [CNT_W-1:0] R_HOLD_L  = CNT_W'(6);
  localparam logic [CNT_W-1:0] N_BASE    = CNT_W'(8);
  localparam logic [CNT_W-1:0] R_BASE    = CNT_W'(12);
  localparam logic [CNT_W-1:0] GAP_BIAS  = CNT_W'(2);

  logic [CNT_W-1:0] wait_w;
  logic [CNT_W-1:0] cycle_len;

  always_comb begin
    wait_w = CNT_W'(wait_cnt);
    if (relaxed) begin
      setup_len = setup_ext ? R_SETUP_L : R_SETUP_S;
      hold_len  = hold_ext  ? R_HOLD_L  : R_HOLD_S;
      cycle_len = R_BASE + (wait_w << 3);
      gap_len   = (wait_w + GAP_BIAS) << 5;
    end else begin
      setup_len = setup_ext ? N_SETUP_L : N_SETUP_S;
      hold_len  = hold_ext  ? N_HOLD_L  : N_HOLD_S;
      cycle_len = N_BASE + (wait_w << 2);
      gap_len   = (wait_w + GAP_BIAS) << 4;
    end
    strobe_len = cycle_len - setup_len - hold_len;
  end

endmodule

// File: rtl/nand_seq_phase.sv
module nand_seq_phase
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             gap_en,
  output phase_e           phase
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] strobe_q, hold_q, gap_q;
  logic             gap_en_q;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE, PH_DONE: begin
        if (start) begin
          if (setup_len != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = setup_len - ONE;
          end else begin
            phase_d = PH_STROBE;
            cnt_d   = strobe_len - ONE;
          end
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = strobe_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          if (gap_en_q) begin
            phase_d = PH_GAP;
            cnt_d   = gap_q - ONE;
          end else begin
            phase_d = PH_DONE;
          end
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_GAP: begin
        if (cnt_q == '0) begin
          phase_d = PH_DONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: begin
        phase_d = PH_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Timing captured once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      hold_q   <= '0;
      gap_q    <= '0;
      gap_en_q <= 1'b0;
    end else if (start) begin
      strobe_q <= strobe_len;
      hold_q   <= hold_len;
      gap_q    <= gap_len;
      gap_en_q <= gap_en;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int SCY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [BUS_W-1:0] req_byte,
  input  logic             req_last_addr,
  input  logic             cfg_relaxed,
  input  logic             cfg_hold_ext,
  input  logic             cfg_setup_ext,
  input  logic [SCY_W-1:0] cfg_wait,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic [BUS_W-1:0] nand_io_out,
  output logic             nand_io_oe,
  output logic             busy,
  output logic             done
);

  // Longest count: relaxed gap 32*(2^SCY_W+1) quarter clocks.
  localparam int MAX_CNT = 32 * ((1 << SCY_W) + 1);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             rst_sync_n;
  phase_e           phase;
  logic             in_cycle;
  logic             start;
  logic             gap_en;
  logic [CNT_W-1:0] setup_len, strobe_len, hold_len, gap_len;
  req_kind_e        kind_q;
  logic [BUS_W-1:0] byte_q;

  assign in_cycle = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign busy     = in_cycle || (phase == PH_GAP);
  assign start    = req_valid && !busy;
  assign gap_en   = (req_kind_e'(req_kind) == KIND_ADDR) && req_last_addr;

  nand_seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nand_seq_timing #(.SCY_W(SCY_W), .CNT_W(CNT_W)) u_timing (
    .relaxed    (cfg_relaxed),
    .hold_ext   (cfg_hold_ext),
    .setup_ext  (cfg_setup_ext),
    .wait_cnt   (cfg_wait),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .gap_len    (gap_len)
  );

  nand_seq_phase #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .gap_len    (gap_len),
    .gap_en     (gap_en),
    .phase      (phase)
  );

  // Request capture, enabled by acceptance only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kind_q <= KIND_DATA;
      byte_q <= '0;
    end else if (start) begin
      kind_q <= req_kind_e'(req_kind);
      byte_q <= req_byte;
    end
  end

  // Pin decode from registered phase and captured request
  always_comb begin
    nand_cle    = in_cycle && (kind_q == KIND_CMD);
    nand_ale    = in_cycle && (kind_q == KIND_ADDR);
    nand_we_n   = (phase != PH_STROBE);
    nand_io_oe  = in_cycle;
    nand_io_out = in_cycle ? byte_q : '0;
    done        = (phase == PH_DONE);
  end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cle,
  input logic             ale,
  input logic             we_n,
  input logic [BUS_W-1:0] io_out,
  input logic             io_oe,
  input logic             busy,
  input logic             done
);

  AST_ONE_LATCH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R2

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && $past(io_oe)) |-> $stable(io_out)); // R2

  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (busy && io_oe)); // R7

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !io_oe) |-> (we_n && !cle && !ale)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && !io_oe && !cle && !ale)); // R1

  AST_LATCH_FALL_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cle) || $fell(ale)) |-> (we_n && $past(we_n))); // R11

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cle    (nand_cle),
  .ale    (nand_ale),
  .we_n   (nand_we_n),
  .io_out (nand_io_out),
  .io_oe  (nand_io_oe),
  .busy   (busy),
  .done   (done)
);

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [7:0] req_byte;
  logic       req_last_addr;
  logic       cfg_relaxed, cfg_hold_ext, cfg_setup_ext;
  logic [3:0] cfg_wait;
  logic       nand_cle, nand_ale, nand_we_n, nand_io_oe, busy, done;
  logic [7:0] nand_io_out;

  always #4 clk = ~clk; // 125 MHz

  nand_cmd_seq u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .req_last_addr(req_last_addr),
    .cfg_relaxed(cfg_relaxed), .cfg_hold_ext(cfg_hold_ext),
    .cfg_setup_ext(cfg_setup_ext), .cfg_wait(cfg_wait),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .busy(busy), .done(done)
  );

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       we_n;
    logic       oe;
    logic [7:0] io;
    logic       busy;
    logic       done;
  } obs_t;

  localparam obs_t IDLE_OBS = '{cle:1'b0, ale:1'b0, we_n:1'b1, oe:1'b0,
                                io:8'h00, busy:1'b0, done:1'b0};

  obs_t  q[$];
  obs_t  exp_o, act_o;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    wd    = 0;
  bit    chk_on = 1'b0;
  string cur_tag = "R1";

  // Behavioural model: expected pins for each fast clock of one request.
  function automatic void plan(int kind, logic [7:0] b, bit last, bit trlx,
                               bit cht, bit cst, int w);
    int   su, ho, tot, gap;
    obs_t e;
    su  = trlx ? (cst ? 4 : 0) : (cst ? 2 : 1);
    ho  = trlx ? (cht ? 6 : 4) : (cht ? 4 : 2);
    tot = trlx ? 4 * (3 + 2 * w) : 4 * (2 + w);
    gap = trlx ? 32 * (2 + w) : 16 * (2 + w);
    e = '{cle:(kind == 0), ale:(kind == 1), we_n:1'b1, oe:1'b1,
          io:b, busy:1'b1, done:1'b0};
    for (int i = 0; i < su; i++) q.push_back(e);
    e.we_n = 1'b0;
    for (int i = 0; i < tot - su - ho; i++) q.push_back(e);
    e.we_n = 1'b1;
    for (int i = 0; i < ho; i++) q.push_back(e);
    if (kind == 1 && last) begin
      e = IDLE_OBS;
      e.busy = 1'b1;
      for (int i = 0; i < gap; i++) q.push_back(e);
    end
    e = IDLE_OBS;
    e.done = 1'b1;
    q.push_back(e);
  endfunction

  function automatic string field_tag(obs_t a, obs_t x);
    if (a.we_n !== x.we_n)                return "R7";
    if (a.cle !== x.cle || a.ale !== x.ale) return "R2";
    if (a.oe !== x.oe || a.io !== x.io)   return "R2";
    if (a.busy !== x.busy)                return "R5";
    return "R9";
  endfunction

  // Compare every clock, away from the active edge, then advance the model.
  always @(negedge clk) begin
    exp_o = (q.size() != 0) ? q[0] : IDLE_OBS;
    act_o = '{cle:nand_cle, ale:nand_ale, we_n:nand_we_n, oe:nand_io_oe,
              io:nand_io_out, busy:busy, done:done};
    if (chk_on) begin
      n_cmp++;
      if (act_o !== exp_o) begin
        n_bad++;
        $display("FAIL %s/%s t=%0t actual cle%b ale%b we_n%b oe%b io%h busy%b done%b expected cle%b ale%b we_n%b oe%b io%h busy%b done%b",
                 cur_tag, field_tag(act_o, exp_o), $time,
                 act_o.cle, act_o.ale, act_o.we_n, act_o.oe, act_o.io, act_o.busy, act_o.done,
                 exp_o.cle, exp_o.ale, exp_o.we_n, exp_o.oe, exp_o.io, exp_o.busy, exp_o.done);
      end
    end
    if (q.size() != 0) void'(q.pop_front());
    if (rst_n === 1'b1 && req_valid === 1'b1 && !exp_o.busy)
      plan(int'(req_kind), req_byte, req_last_addr, cfg_relaxed,
           cfg_hold_ext, cfg_setup_ext, int'(cfg_wait));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual busy=%b expected idle", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic drive(int kind, logic [7:0] b, bit last, bit trlx,
                       bit cht, bit cst, int w);
    req_kind      = 2'(kind);
    req_byte      = b;
    req_last_addr = last;
    cfg_relaxed   = trlx;
    cfg_hold_ext  = cht;
    cfg_setup_ext = cst;
    cfg_wait      = 4'(w);
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (q.size() != 0);
    @(posedge clk);
  endtask

  task automatic send(int kind, logic [7:0] b, bit last, bit trlx,
                      bit cht, bit cst, int w);
    @(posedge clk); #2;
    drive(kind, b, last, trlx, cht, cst, w);
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    drive(0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    #10 chk_on = 1'b1;
    // R1: reset state, including a request presented during reset
    req_valid = 1'b1;
    repeat (4) @(posedge clk);
    #2 req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (6) @(posedge clk);

    // R2 R5: command cycle, all options zero (two bus clocks)
    cur_tag = "R2";
    send(0, 8'h70, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    send(2, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    send(3, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1);   // kind 3 acts as data

    // R3 R4 R7: all eight timing variants on address and data cycles
    cur_tag = "R3";
    for (int v = 0; v < 8; v++) begin
      send(1, 8'(8'h10 + v), 1'b0, v[2], v[1], v[0], v);
      send(2, 8'(8'hC0 + v), 1'b0, v[2], v[1], v[0], 7 - v);
    end
    cur_tag = "R4";
    send(0, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 0);
    send(0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 0);

    // R5 R6: largest wait count in both modes
    cur_tag = "R5";
    send(0, 8'h90, 1'b0, 1'b0, 1'b0, 1'b1, 15);
    cur_tag = "R6";
    send(2, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 15);

    // R8: gap after last address, and flag ignored elsewhere
    cur_tag = "R8";
    send(1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1);
    send(1, 8'h02, 1'b1, 1'b1, 1'b0, 1'b1, 0);
    send(1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    send(0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    send(2, 8'h05, 1'b1, 1'b1, 1'b0, 1'b0, 0);

    // R10: requests and configuration changes while busy are ignored
    cur_tag = "R10";
    @(posedge clk); #2;
    drive(0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    req_valid = 1'b1;
    @(posedge clk); #2;
    drive(1, 8'hEE, 1'b1, 1'b1, 1'b1, 1'b1, 9);
    repeat (5) @(posedge clk);
    #2 req_valid = 1'b0;
    wait_idle();
    @(posedge clk); #2;
    drive(1, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    req_valid = 1'b1;
    @(posedge clk); #2;
    drive(0, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    repeat (20) @(posedge clk);
    #2 req_valid = 1'b0;
    wait_idle();

    // R9 R11: request held high, accepted in each done clock
    cur_tag = "R9";
    @(posedge clk); #2;
    drive(0, 8'h60, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    req_valid = 1'b1;
    repeat (40) @(posedge clk);
    #2 req_valid = 1'b0;
    wait_idle();
    cur_tag = "R11";
    @(posedge clk); #2;
    drive(1, 8'h61, 1'b0, 1'b1, 1'b0, 1'b0, 1);
    req_valid = 1'b1;
    repeat (45) @(posedge clk);
    #2 req_valid = 1'b0;
    wait_idle();

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule